// File: doc/BRIEF.md
# Predicated bit-serial multiply sequencer

This block is the control state machine for an array of bit-serial compute columns in which every operand is stored transposed: bit j of an operand sits in row base+j, and each column holds one element. On a start strobe it issues, one per cycle, an operation code plus up to three row addresses. Run by the array, that stream multiplies an n-bit unsigned multiplicand vector by an n-bit unsigned multiplier vector in every column at once, and leaves a 2n-bit product in 2n consecutive rows. The sequencer holds no data. It only produces the operation stream.

Multiplication is shift-and-add. The shift is done purely by row addressing. Each multiplier bit is first loaded into a per-column predicate (tag) latch. The partial-product pass that follows writes back only in columns whose tag is 1, so columns whose multiplier bit is 0 keep their partial product. Each column also has a carry latch, which an add step reads and then updates.

States: `S_IDLE` goes to `S_ZERO` on start. `S_ZERO` goes to `S_TAG` after the last product row has been cleared. `S_TAG` goes to `S_COPY` in pass 0 and to `S_ADD` in later passes. `S_COPY` goes to `S_DONE` after its last bit when n = 1, and otherwise to `S_TAG`. `S_ADD` goes to `S_CARRY` after its last bit. `S_CARRY` goes to `S_DONE` after the final pass, and otherwise to `S_TAG`. `S_DONE` goes back to `S_IDLE`.

Top module: `mul_seq_top`

## Requirements
- R1: After reset, and whenever idle, `busy` and `done` are 0 and `op_code` is the no-operation code 0.
- R2: A start strobe is accepted only in idle. The cycle after acceptance, `busy` is 1 and the first operation is issued. A start strobe while busy is ignored: operation stream, addresses, product and done count are unchanged.
- R3: The first 2n operations are clear-row (code 1), with `row_w` = product base + j for j = 0 to 2n-1 in ascending order.
- R4: Pass 0 is one load-tag (code 2, `row_a` = multiplier base). The array copies `row_a` into the tag and clears the carry latch. Then come n copy operations (code 3, `row_a` = multiplicand base + j, `row_w` = product base + j). Where the tag is 1, the array writes `row_a` into `row_w`.
- R5: Each pass i from 1 to n-1 is one load-tag (code 2, `row_a` = multiplier base + i). Then come n add operations (code 4, `row_a` = multiplicand base + j, `row_b` = `row_w` = product base + i + j). For each add, the array forms sum and carry-out of `row_a`, `row_b` and the carry latch, writes the sum where the tag is 1, and always updates the carry. The pass ends with one store-carry (code 5, `row_w` = product base + i + n). Where the tag is 1, the array writes the carry into `row_w`.
- R6: For n = 2, the operations after the clears are, in order: load-tag, copy, copy, load-tag, add, add, store-carry.
- R7: One run issues exactly n*n + 4n - 1 operations on consecutive cycles. `done` is then 1 for exactly one cycle with `op_code` 0. `busy` stays 1 from the cycle after acceptance through the done cycle and is 0 in the next cycle.
- R8: A requested width of 0 is run as 1. A width above `W_MAX` is run as `W_MAX`.
- R9: An array executing the stream holds, in every column, the unsigned product of that column's operands in product rows base to base+2n-1 (LSB first), whatever those rows held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, sampled in idle |
| width | input | $clog2(W_MAX+1) | Operand width n |
| mcand_base | input | ROW_AW | Row of multiplicand bit 0 |
| mplier_base | input | ROW_AW | Row of multiplier bit 0 |
| prod_base | input | ROW_AW | Row of product bit 0 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| op_code | output | 3 | Operation for the array this cycle |
| row_a | output | ROW_AW | First read row |
| row_b | output | ROW_AW | Second read row (add only) |
| row_w | output | ROW_AW | Write-back row |

## Verification
The bench models the column array and sweeps every operand pair for widths 1 to 4 across 256 columns. For n = 4 this covers all pairs exactly once. Widths 1 and 2 separate the copy-only pass from the add passes. Widths 3 and 4 bring in carry chains that ripple into the stored-carry rows. Two base placements and pre-filled product rows show that the addresses are correct and that clearing happens. A stray start during a run, and widths of 0 and 7, exercise the acceptance rule and the clamping. Each run also checks the full operation and address stream against a list built from the pass rules.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ZERO = 3'd1,
        OP_TAG  = 3'd2,
        OP_COPY = 3'd3,
        OP_ADD  = 3'd4,
        OP_STC  = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ZERO,
        S_TAG,
        S_COPY,
        S_ADD,
        S_CARRY,
        S_DONE
    } state_e;

endpackage

// File: rtl/mul_seq_wclamp.sv
module mul_seq_wclamp #(
    parameter int W_MAX = 8,
    parameter int WW    = $clog2(W_MAX + 1)
) (
    input  logic [WW-1:0] width_raw,
    output logic [WW-1:0] width_eff
);
    localparam logic [WW-1:0] LIMIT = WW'(W_MAX);

    always_comb begin
        if (width_raw == '0)
            width_eff = WW'(1);
        else if (width_raw > LIMIT)
            width_eff = LIMIT;
        else
            width_eff = width_raw;
    end
endmodule

// File: rtl/mul_seq_addr.sv
module mul_seq_addr #(
    parameter int ROW_AW = 8,
    parameter int CW     = 5
) (
    input  logic [ROW_AW-1:0] mcand_base,
    input  logic [ROW_AW-1:0] mplier_base,
    input  logic [ROW_AW-1:0] prod_base,
    input  logic [CW-1:0]     pass_idx,
    input  logic [CW-1:0]     bit_idx,
    input  logic [CW-1:0]     n_ops,
    output logic [ROW_AW-1:0] a_mplier,
    output logic [ROW_AW-1:0] a_mcand,
    output logic [ROW_AW-1:0] a_prod,
    output logic [ROW_AW-1:0] a_carry
);
    // Shift-and-add by addressing: pass i aligns the multiplicand at product row i.
    assign a_mplier = mplier_base + ROW_AW'(pass_idx);
    assign a_mcand  = mcand_base + ROW_AW'(bit_idx);
    assign a_prod   = prod_base + ROW_AW'(pass_idx) + ROW_AW'(bit_idx);
    assign a_carry  = prod_base + ROW_AW'(pass_idx) + ROW_AW'(n_ops);
endmodule

// File: rtl/mul_seq_top.sv
module mul_seq_top #(
    parameter int ROW_AW = 8,
    parameter int W_MAX  = 8,
    parameter int WW     = $clog2(W_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WW-1:0]     width,
    input  logic [ROW_AW-1:0] mcand_base,
    input  logic [ROW_AW-1:0] mplier_base,
    input  logic [ROW_AW-1:0] prod_base,
    output logic              busy,
    output logic              done,
    output logic [2:0]        op_code,
    output logic [ROW_AW-1:0] row_a,
    output logic [ROW_AW-1:0] row_b,
    output logic [ROW_AW-1:0] row_w
);
    import mul_seq_pkg::*;

    localparam int CW = $clog2(2 * W_MAX + 1);

    state_e            state_q, state_d;
    logic [CW-1:0]     pass_q, pass_d;
    logic [CW-1:0]     bit_q, bit_d;
    logic [WW-1:0]     n_q;
    logic [WW-1:0]     n_eff;
    logic [ROW_AW-1:0] mcand_q, mplier_q, prod_q;

    logic [CW-1:0]     n_c, n_last, z_last;
    logic [ROW_AW-1:0] a_mplier, a_mcand, a_prod, a_carry;
    op_e               op_w;

    mul_seq_wclamp #(.W_MAX(W_MAX), .WW(WW)) u_wclamp (
        .width_raw (width),
        .width_eff (n_eff)
    );

    assign n_c    = CW'(n_q);
    assign n_last = n_c - CW'(1);
    assign z_last = (n_c << 1) - CW'(1);

    mul_seq_addr #(.ROW_AW(ROW_AW), .CW(CW)) u_addr (
        .mcand_base  (mcand_q),
        .mplier_base (mplier_q),
        .prod_base   (prod_q),
        .pass_idx    (pass_q),
        .bit_idx     (bit_q),
        .n_ops       (n_c),
        .a_mplier    (a_mplier),
        .a_mcand     (a_mcand),
        .a_prod      (a_prod),
        .a_carry     (a_carry)
    );

    // Next state and loop counters.
    always_comb begin
        state_d = state_q;
        pass_d  = pass_q;
        bit_d   = bit_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = S_ZERO;
                    pass_d  = '0;
                    bit_d   = '0;
                end
            end
            S_ZERO: begin
                if (bit_q == z_last) begin
                    state_d = S_TAG;
                    bit_d   = '0;
                end else begin
                    bit_d = bit_q + CW'(1);
                end
            end
            S_TAG: begin
                state_d = (pass_q == '0) ? S_COPY : S_ADD;
                bit_d   = '0;
            end
            S_COPY: begin
                if (bit_q == n_last) begin
                    state_d = (n_c == CW'(1)) ? S_DONE : S_TAG;
                    pass_d  = CW'(1);
                    bit_d   = '0;
                end else begin
                    bit_d = bit_q + CW'(1);
                end
            end
            S_ADD: begin
                if (bit_q == n_last)
                    state_d = S_CARRY;
                else
                    bit_d = bit_q + CW'(1);
            end
            S_CARRY: begin
                bit_d = '0;
                if (pass_q == n_last) begin
                    state_d = S_DONE;
                end else begin
                    state_d = S_TAG;
                    pass_d  = pass_q + CW'(1);
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register; operand geometry is captured only on acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            pass_q   <= '0;
            bit_q    <= '0;
            n_q      <= WW'(1);
            mcand_q  <= '0;
            mplier_q <= '0;
            prod_q   <= '0;
        end else begin
            state_q <= state_d;
            pass_q  <= pass_d;
            bit_q   <= bit_d;
            if (state_q == S_IDLE && start) begin
                n_q      <= n_eff;
                mcand_q  <= mcand_base;
                mplier_q <= mplier_base;
                prod_q   <= prod_base;
            end
        end
    end

    // Per-state operation and row addresses.
    always_comb begin
        op_w  = OP_NOP;
        row_a = '0;
        row_b = '0;
        row_w = '0;
        busy  = (state_q != S_IDLE);
        done  = (state_q == S_DONE);
        unique case (state_q)
            S_IDLE: ;
            S_ZERO: begin
                op_w  = OP_ZERO;
                row_w = a_prod;
            end
            S_TAG: begin
                op_w  = OP_TAG;
                row_a = a_mplier;
            end
            S_COPY: begin
                op_w  = OP_COPY;
                row_a = a_mcand;
                row_w = a_prod;
            end
            S_ADD: begin
                op_w  = OP_ADD;
                row_a = a_mcand;
                row_b = a_prod;
                row_w = a_prod;
            end
            S_CARRY: begin
                op_w  = OP_STC;
                row_w = a_carry;
            end
            S_DONE: ;
            default: ;
        endcase
    end

    assign op_code = op_w;

endmodule

// File: rtl/mul_seq_chk.sv
module mul_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] op_code
);
    import mul_seq_pkg::*;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (op_code == OP_NOP && !done));

    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && op_code == OP_ZERO));

    p_zero_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (op_code == OP_ZERO));

    p_tag_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_TAG) |=> (op_code == OP_COPY || op_code == OP_ADD));

    p_carry_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_STC) |=> (op_code == OP_TAG || done));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind mul_seq_top mul_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .op_code (op_code)
);

// File: tb/tb_mul_seq_top.sv
`timescale 1ns/1ps
module tb_mul_seq_top;
    localparam int RA   = 6;
    localparam int WM   = 4;
    localparam int WW   = 3;
    localparam int COLS = 256;
    localparam int NR   = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [WW-1:0] width = '0;
    logic [RA-1:0] mcand_base = '0, mplier_base = '0, prod_base = '0;
    logic          busy, done;
    logic [2:0]    op_code;
    logic [RA-1:0] row_a, row_b, row_w;

    always #2.5 clk = ~clk;

    mul_seq_top #(.ROW_AW(RA), .W_MAX(WM)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .width(width),
        .mcand_base(mcand_base), .mplier_base(mplier_base), .prod_base(prod_base),
        .busy(busy), .done(done), .op_code(op_code),
        .row_a(row_a), .row_b(row_b), .row_w(row_w)
    );

    int checks = 0;
    int errors = 0;

    // Array model and stream monitor state.
    logic [COLS-1:0] mem [NR];
    logic [COLS-1:0] tag, carry;
    int exp_op [64];
    int exp_a  [64];
    int exp_b  [64];
    int exp_w  [64];
    int exp_len;
    int k, done_cnt, busy_cnt, seq_err;
    string seq_msg;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int o, input int a, input int b, input int w);
        exp_op[exp_len] = o;
        exp_a[exp_len]  = a;
        exp_b[exp_len]  = b;
        exp_w[exp_len]  = w;
        exp_len++;
    endtask

    always @(negedge clk) begin
        logic [COLS-1:0] s, cy, ra, rb;
        if (busy) busy_cnt++;
        if (done) done_cnt++;
        if (op_code != 3'd0) begin
            if (k >= exp_len) begin
                seq_err++;
                if (seq_err == 1) seq_msg = $sformatf("extra op %0d at step %0d", op_code, k);
            end else if (int'(op_code) != exp_op[k]
                     || ((op_code == 3'd2 || op_code == 3'd3 || op_code == 3'd4) && int'(row_a) != exp_a[k])
                     || (op_code == 3'd4 && int'(row_b) != exp_b[k])
                     || (op_code != 3'd2 && int'(row_w) != exp_w[k])) begin
                seq_err++;
                if (seq_err == 1)
                    seq_msg = $sformatf("step %0d op=%0d a=%0d b=%0d w=%0d want op=%0d a=%0d b=%0d w=%0d",
                                        k, op_code, row_a, row_b, row_w,
                                        exp_op[k], exp_a[k], exp_b[k], exp_w[k]);
            end
            k++;
            ra = mem[row_a];
            rb = mem[row_b];
            case (op_code)
                3'd1: mem[row_w] = '0;
                3'd2: begin tag = ra; carry = '0; end
                3'd3: mem[row_w] = (ra & tag) | (mem[row_w] & ~tag);
                3'd4: begin
                    s  = ra ^ rb ^ carry;
                    cy = (ra & rb) | (ra & carry) | (rb & carry);
                    mem[row_w] = (s & tag) | (mem[row_w] & ~tag);
                    carry = cy;
                end
                3'd5: mem[row_w] = (carry & tag) | (mem[row_w] & ~tag);
                default: ;
            endcase
        end
    end

    task automatic run_case(input int wraw, input int n, input int mb, input int qb,
                            input int pb, input bit stray, input string rq);
        int waited;
        int bad;
        // Column c holds multiplicand c mod 2^n and multiplier (c >> n) mod 2^n.
        for (int c = 0; c < COLS; c++) begin
            int av, bv;
            av = c % (1 << n);
            bv = (c >> n) % (1 << n);
            for (int j = 0; j < n; j++) begin
                mem[mb + j][c] = av[j];
                mem[qb + j][c] = bv[j];
            end
            for (int j = 0; j < 2 * WM; j++) mem[pb + j][c] = 1'b1;
        end
        // Expected stream from R3, R4, R5.
        exp_len = 0;
        for (int j = 0; j < 2 * n; j++) push(1, 0, 0, pb + j);
        push(2, qb, 0, 0);
        for (int j = 0; j < n; j++) push(3, mb + j, 0, pb + j);
        for (int i = 1; i < n; i++) begin
            push(2, qb + i, 0, 0);
            for (int j = 0; j < n; j++) push(4, mb + j, pb + i + j, pb + i + j);
            push(5, 0, 0, pb + i + n);
        end
        k = 0; done_cnt = 0; busy_cnt = 0; seq_err = 0; seq_msg = "";
        @(negedge clk);
        width = WW'(wraw);
        mcand_base = RA'(mb); mplier_base = RA'(qb); prod_base = RA'(pb);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accepted start", busy, 1);
        if (stray) begin
            repeat (3) @(negedge clk);
            mcand_base = RA'(30); mplier_base = RA'(31); prod_base = RA'(32);
            width = WW'(1);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (done_cnt == 0 && waited < 500) begin
            @(negedge clk);
            waited++;
        end
        repeat (4) @(negedge clk);
        chk(seq_err == 0, (n == 2) ? "R6" : "R5", {rq, " op/address stream ", seq_msg}, seq_err, 0);
        chk(k == n * n + 4 * n - 1, "R7", {rq, " op count"}, k, n * n + 4 * n - 1);
        chk(done_cnt == 1, "R7", {rq, " done pulse cycles"}, done_cnt, 1);
        chk(busy_cnt == k + 1, "R7", {rq, " busy cycles"}, busy_cnt, k + 1);
        chk(busy == 1'b0 && op_code == 3'd0, "R1", {rq, " idle after run"}, busy, 0);
        bad = 0;
        for (int c = 0; c < COLS; c++) begin
            int av, bv, pr;
            av = c % (1 << n);
            bv = (c >> n) % (1 << n);
            pr = 0;
            for (int j = 0; j < 2 * n; j++) pr = pr | (int'(mem[pb + j][c]) << j);
            if (pr != av * bv) begin
                if (bad == 0)
                    chk(1'b0, "R9", $sformatf("%s col %0d %0d*%0d", rq, c, av, bv), pr, av * bv);
                bad++;
            end
        end
        if (bad == 0) chk(1'b1, "R9", rq, 0, 0);
        if (stray) chk(bad == 0 && seq_err == 0 && done_cnt == 1, "R2",
                       "start while busy altered the run", bad + seq_err, 0);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && op_code == 3'd0, "R1", "reset outputs",
            {busy, done, op_code}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && op_code == 3'd0, "R1", "idle before start", op_code, 0);

        run_case(1, 1, 0, 4, 8, 1'b0, "R4 n=1");
        run_case(2, 2, 0, 4, 8, 1'b0, "R6 n=2");
        run_case(3, 3, 0, 4, 8, 1'b0, "R5 n=3");
        run_case(4, 4, 0, 4, 8, 1'b0, "R5 n=4");
        run_case(2, 2, 50, 40, 20, 1'b0, "R3 n=2 moved");
        run_case(3, 3, 50, 40, 20, 1'b1, "R2 n=3 stray start");
        run_case(0, 1, 50, 40, 20, 1'b0, "R8 width 0");
        run_case(7, 4, 0, 4, 8, 1'b0, "R8 width 7");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule